// File: doc/BRIEF.md
# Banked Working-Register and Status Unit

This unit holds the data-side working state of a small 8-bit accumulator core: 32 bytes of working registers in four banks of eight, an accumulator, a scratch/operand register B and a status byte. The execute stage names a working register by its 3-bit number. The unit adds the active bank, which it takes from two bank-select bits in the status byte. The same 32 bytes also answer as direct data addresses 0x00 to 0x1F, so register access and direct access share one storage.

The unit has one write port and two combinational read ports. The write port has four kinds: working-register byte, direct byte, single bit, and reserved. The ALU has a separate flag port for carry, auxiliary carry and overflow. The parity flag is not stored. It is always the XOR of the accumulator bits.

Top module: `regbank_unit`

## Requirements
- R1: A working-register access to Rn (n = addr[2:0]) reaches storage byte {bank[1:0], n}. The same byte is reachable as direct address 0x00 to 0x1F, and a value written through one path reads back through the other.
- R2: The bank is status bits [4:3] (bank_o). After the bank changes, Rn accesses reach the new bank and the other banks keep their contents.
- R3: Reads are combinational. A read of a byte written in the same cycle returns the old value. The new value is visible from the cycle after the write edge.
- R4: Status bit 0 is 1 exactly when the accumulator holds an odd number of ones. It follows every accumulator change, and byte or bit writes to status bit 0 have no effect.
- R5: For direct byte access, 0xE0 is the accumulator, 0xF0 is B and 0xD0 is the status byte. Any other direct address above 0x1F is ignored on write and reads as 0x00. A write of kind 3 (reserved) changes nothing.
- R6: A bit write (kind 2) with bit address 0xD0+k, 0xE0+k or 0xF0+k sets bit k of the status byte, accumulator or B to wr_data_i[0], leaving all other bits unchanged. Any other bit address is ignored.
- R7: When its enable is set, the flag port loads carry (status bit 7, flag_en_i[2]), auxiliary carry (bit 6, flag_en_i[1]) and overflow (bit 2, flag_en_i[0]). If a status write falls in the same cycle, the flag port wins on its enabled bits and the write supplies the rest.
- R8: Asynchronous active-low reset clears the accumulator, B and the status byte, so bank 0 is selected and the parity bit is 0.
- R9: acc_o, b_o, psw_o and bank_o always show the current accumulator, B, status byte (with parity) and bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_kind_i | input | 2 | 0 register Rn, 1 direct byte, 2 bit, 3 reserved |
| wr_addr_i | input | 8 | Register number, direct address or bit address |
| wr_data_i | input | 8 | Write byte; bit 0 is the value for bit writes |
| flag_en_i | input | 3 | Flag load enables {carry, aux carry, overflow} |
| flag_val_i | input | 3 | Flag values {carry, aux carry, overflow} |
| rd0_is_reg_i | input | 1 | Read port 0: 1 selects Rn, 0 direct address |
| rd0_addr_i | input | 8 | Read port 0 address |
| rd0_data_o | output | 8 | Read port 0 data |
| rd1_is_reg_i | input | 1 | Read port 1: 1 selects Rn, 0 direct address |
| rd1_addr_i | input | 8 | Read port 1 address |
| rd1_data_o | output | 8 | Read port 1 data |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | B register |
| psw_o | output | 8 | Status byte including live parity |
| bank_o | output | 2 | Active bank |

## Verification
Two events can land on the status byte in one cycle: a byte or bit write to it, and an ALU flag load. The bench issues a direct status write of 0x00 while loading carry and overflow to 1. It expects carry and overflow set and the bank cleared. It also pairs a bit write of carry with a flag load of carry to the opposite value, and expects the flag value to win. A second same-cycle case is a read of a byte that is being written. The bench expects the old data before the edge and the new data on both read ports after it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned REGS_BANK = 8;
  localparam int unsigned BANKS     = 4;
  localparam int unsigned READ_PORTS = 2;

  localparam logic [7:0] SFR_PSW = 8'hD0;
  localparam logic [7:0] SFR_ACC = 8'hE0;
  localparam logic [7:0] SFR_B   = 8'hF0;

  // status byte bit positions
  localparam int unsigned ST_CY  = 7;
  localparam int unsigned ST_AC  = 6;
  localparam int unsigned ST_RSH = 4;
  localparam int unsigned ST_RSL = 3;
  localparam int unsigned ST_OV  = 2;

  typedef enum logic [1:0] {
    K_REG    = 2'd0,
    K_DIRECT = 2'd1,
    K_BIT    = 2'd2,
    K_NONE   = 2'd3
  } wr_kind_e;

  typedef enum logic [2:0] {
    T_NONE = 3'd0,
    T_RF   = 3'd1,
    T_ACC  = 3'd2,
    T_B    = 3'd3,
    T_PSW  = 3'd4
  } target_e;
endpackage

// File: rtl/rb_decode.sv
module rb_decode
  import regbank_pkg::*;
#(
  parameter int unsigned REGS  = REGS_BANK,
  parameter int unsigned NBANK = BANKS,
  localparam int unsigned RW   = $clog2(REGS),
  localparam int unsigned BW   = $clog2(NBANK),
  localparam int unsigned AW   = RW + BW
) (
  input  logic [1:0]    kind_i,
  input  logic [7:0]    addr_i,
  input  logic [BW-1:0] bank_i,
  output target_e       tgt_o,
  output logic [AW-1:0] idx_o
);
  localparam int unsigned DEPTH = REGS * NBANK;

  always_comb begin
    tgt_o = T_NONE;
    idx_o = '0;
    unique case (wr_kind_e'(kind_i))
      K_REG: begin
        tgt_o = T_RF;
        idx_o = {bank_i, addr_i[RW-1:0]};
      end
      K_DIRECT: begin
        if (32'(addr_i) < DEPTH) begin
          tgt_o = T_RF;
          idx_o = addr_i[AW-1:0];
        end else if (addr_i == SFR_ACC) tgt_o = T_ACC;
        else if (addr_i == SFR_B)       tgt_o = T_B;
        else if (addr_i == SFR_PSW)     tgt_o = T_PSW;
      end
      K_BIT: begin
        if (addr_i[7:3] == SFR_ACC[7:3])      tgt_o = T_ACC;
        else if (addr_i[7:3] == SFR_B[7:3])   tgt_o = T_B;
        else if (addr_i[7:3] == SFR_PSW[7:3]) tgt_o = T_PSW;
      end
      default: tgt_o = T_NONE;
    endcase
  end
endmodule

// File: rtl/rb_storage.sv
module rb_storage
  import regbank_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned REGS  = REGS_BANK,
  parameter int unsigned NBANK = BANKS,
  parameter int unsigned NRD   = READ_PORTS,
  localparam int unsigned DEPTH = REGS * NBANK,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           widx_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]  ridx_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem_q[ridx_i[p]];
  end

  // R3: written byte holds the written value after the edge
  p_wr_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/rb_sfr.sv
module rb_sfr
  import regbank_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  localparam int unsigned BPW = $clog2(DW)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DW-1:0]  wdata_i,
  input  logic           acc_we_i,
  input  logic           b_we_i,
  input  logic           psw_we_i,
  input  logic           acc_bwe_i,
  input  logic           b_bwe_i,
  input  logic           psw_bwe_i,
  input  logic [BPW-1:0] bitpos_i,
  input  logic [2:0]     flag_en_i,
  input  logic [2:0]     flag_val_i,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  b_o,
  output logic [DW-1:0]  psw_o
);
  logic [DW-1:0] acc_q, acc_d, b_q, b_d;
  logic [DW-1:1] psw_q, psw_d;
  logic [DW-1:0] psw_full;
  logic          bit_val;

  assign bit_val = wdata_i[0];

  always_comb begin
    acc_d = acc_q;
    if (acc_we_i)  acc_d = wdata_i;
    if (acc_bwe_i) acc_d[bitpos_i] = bit_val;
  end

  always_comb begin
    b_d = b_q;
    if (b_we_i)  b_d = wdata_i;
    if (b_bwe_i) b_d[bitpos_i] = bit_val;
  end

  // flag port overrides a coincident status write on its enabled bits
  always_comb begin
    psw_full = {psw_q, 1'b0};
    if (psw_we_i)  psw_full = wdata_i;
    if (psw_bwe_i) psw_full[bitpos_i] = bit_val;
    if (flag_en_i[2]) psw_full[ST_CY] = flag_val_i[2];
    if (flag_en_i[1]) psw_full[ST_AC] = flag_val_i[1];
    if (flag_en_i[0]) psw_full[ST_OV] = flag_val_i[0];
    psw_d = psw_full[DW-1:1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      b_q   <= '0;
      psw_q <= '0;
    end else begin
      acc_q <= acc_d;
      b_q   <= b_d;
      psw_q <= psw_d;
    end
  end

  assign acc_o = acc_q;
  assign b_o   = b_q;
  assign psw_o = {psw_q, ^acc_q};

  // R4: a single-bit accumulator change flips parity
  p_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(acc_o ^ $past(acc_o)) == 1) |-> (psw_o[0] != $past(psw_o[0])));

  // R7: enabled carry load lands on the next cycle
  p_flag_cy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i[2] |=> psw_o[ST_CY] == $past(flag_val_i[2]));

  p_flag_ov_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_en_i[0] |=> psw_o[ST_OV] == $past(flag_val_i[0]));

  // R5: no write and no flag load keeps all three registers
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc_we_i || b_we_i || psw_we_i || acc_bwe_i || b_bwe_i || psw_bwe_i || (|flag_en_i))
    |=> ($stable(acc_o) && $stable(b_o) && $stable(psw_o)));
endmodule

// File: rtl/regbank_unit.sv
module regbank_unit
  import regbank_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned REGS  = REGS_BANK,
  parameter int unsigned NBANK = BANKS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [7:0]    wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [2:0]    flag_en_i,
  input  logic [2:0]    flag_val_i,
  input  logic          rd0_is_reg_i,
  input  logic [7:0]    rd0_addr_i,
  output logic [7:0]    rd0_data_o,
  input  logic          rd1_is_reg_i,
  input  logic [7:0]    rd1_addr_i,
  output logic [7:0]    rd1_data_o,
  output logic [7:0]    acc_o,
  output logic [7:0]    b_o,
  output logic [7:0]    psw_o,
  output logic [1:0]    bank_o
);
  localparam int unsigned NRD   = READ_PORTS;
  localparam int unsigned DEPTH = REGS * NBANK;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned BW    = $clog2(NBANK);
  localparam int unsigned BPW   = $clog2(DW);

  logic [BW-1:0]          bank;
  target_e                wr_tgt;
  logic [AW-1:0]          wr_idx;
  logic                   wr_bit, wr_byte;
  logic [NRD-1:0]         rd_is_reg;
  logic [NRD-1:0][7:0]    rd_addr;
  logic [NRD-1:0][AW-1:0] rd_idx;
  logic [NRD-1:0][DW-1:0] rf_rdata;
  logic [NRD-1:0][DW-1:0] rd_data;
  target_e                rd_tgt [NRD];

  assign bank = psw_o[ST_RSH:ST_RSL];

  rb_decode #(.REGS(REGS), .NBANK(NBANK)) u_wr_dec (
    .kind_i (wr_kind_i),
    .addr_i (wr_addr_i),
    .bank_i (bank),
    .tgt_o  (wr_tgt),
    .idx_o  (wr_idx)
  );

  assign wr_bit  = wr_en_i && (wr_kind_e'(wr_kind_i) == K_BIT);
  assign wr_byte = wr_en_i && !wr_bit;

  assign rd_is_reg = {rd1_is_reg_i, rd0_is_reg_i};
  assign rd_addr   = {rd1_addr_i, rd0_addr_i};

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rb_decode #(.REGS(REGS), .NBANK(NBANK)) u_rd_dec (
      .kind_i (rd_is_reg[p] ? K_REG : K_DIRECT),
      .addr_i (rd_addr[p]),
      .bank_i (bank),
      .tgt_o  (rd_tgt[p]),
      .idx_o  (rd_idx[p])
    );

    always_comb begin
      unique case (rd_tgt[p])
        T_RF:    rd_data[p] = rf_rdata[p];
        T_ACC:   rd_data[p] = acc_o;
        T_B:     rd_data[p] = b_o;
        T_PSW:   rd_data[p] = psw_o;
        default: rd_data[p] = '0;
      endcase
    end
  end

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];

  rb_storage #(.DW(DW), .REGS(REGS), .NBANK(NBANK), .NRD(NRD)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_byte && (wr_tgt == T_RF)),
    .widx_i  (wr_idx),
    .wdata_i (wr_data_i),
    .ridx_i  (rd_idx),
    .rdata_o (rf_rdata)
  );

  rb_sfr #(.DW(DW)) u_sfr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdata_i    (wr_data_i),
    .acc_we_i   (wr_byte && (wr_tgt == T_ACC)),
    .b_we_i     (wr_byte && (wr_tgt == T_B)),
    .psw_we_i   (wr_byte && (wr_tgt == T_PSW)),
    .acc_bwe_i  (wr_bit && (wr_tgt == T_ACC)),
    .b_bwe_i    (wr_bit && (wr_tgt == T_B)),
    .psw_bwe_i  (wr_bit && (wr_tgt == T_PSW)),
    .bitpos_i   (wr_addr_i[BPW-1:0]),
    .flag_en_i  (flag_en_i),
    .flag_val_i (flag_val_i),
    .acc_o      (acc_o),
    .b_o        (b_o),
    .psw_o      (psw_o)
  );

  assign bank_o = bank;

  // R1: register writes land at {bank, n}
  p_bank_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == 2'd0) |-> wr_idx == {bank_o, wr_addr_i[2:0]});

  // R2: bank only moves on a status write
  p_bank_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_tgt == T_PSW) |=> $stable(bank_o));
endmodule

// File: tb/sim_regbank_unit.sv
module sim_regbank_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_kind = 2'd0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [2:0] flag_en = '0, flag_val = '0;
  logic       rd0_reg = 1'b0, rd1_reg = 1'b0;
  logic [7:0] rd0_addr = '0, rd1_addr = '0;
  logic [7:0] rd0_data, rd1_data, acc, b, psw;
  logic [1:0] bank;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  regbank_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .flag_en_i(flag_en),
    .flag_val_i(flag_val), .rd0_is_reg_i(rd0_reg), .rd0_addr_i(rd0_addr),
    .rd0_data_o(rd0_data), .rd1_is_reg_i(rd1_reg), .rd1_addr_i(rd1_addr),
    .rd1_data_o(rd1_data), .acc_o(acc), .b_o(b), .psw_o(psw), .bank_o(bank)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] kind;
    logic [7:0] wa;
    logic [7:0] wd;
    logic       rreg;
    logic [7:0] ra;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 8'h03, 8'h5A, 1'b0, 8'h03, 8'h5A, 4'd1}, // R1 Rn write, direct read
    '{1'b1, 2'd1, 8'h07, 8'hC3, 1'b1, 8'h07, 8'hC3, 4'd1}, // R1 direct write, Rn read
    '{1'b1, 2'd1, 8'hD0, 8'h10, 1'b0, 8'hD0, 8'h10, 4'd2}, // R2 select bank 2
    '{1'b1, 2'd0, 8'h03, 8'h77, 1'b0, 8'h13, 8'h77, 4'd2}, // R2 R3 of bank 2
    '{1'b0, 2'd0, 8'h00, 8'h00, 1'b0, 8'h03, 8'h5A, 4'd2}, // R2 bank 0 intact
    '{1'b1, 2'd1, 8'hE0, 8'h07, 1'b0, 8'hD0, 8'h11, 4'd4}, // R4 odd acc
    '{1'b1, 2'd1, 8'hE0, 8'h03, 1'b0, 8'hD0, 8'h10, 4'd4}, // R4 even acc
    '{1'b1, 2'd1, 8'hD0, 8'h19, 1'b0, 8'hD0, 8'h18, 4'd4}, // R4 bit 0 write ignored
    '{1'b1, 2'd0, 8'h00, 8'hAB, 1'b0, 8'h18, 8'hAB, 4'd1}, // R1 bank 3 R0
    '{1'b1, 2'd1, 8'hF0, 8'h3C, 1'b0, 8'hF0, 8'h3C, 4'd5}, // R5 B
    '{1'b1, 2'd1, 8'h55, 8'hFF, 1'b0, 8'h55, 8'h00, 4'd5}, // R5 unmapped
    '{1'b1, 2'd2, 8'hF7, 8'h01, 1'b0, 8'hF0, 8'hBC, 4'd6}, // R6 B bit 7
    '{1'b1, 2'd2, 8'hE0, 8'h00, 1'b0, 8'hD0, 8'h19, 4'd6}, // R6 acc bit 0
    '{1'b1, 2'd2, 8'hD4, 8'h00, 1'b0, 8'hD0, 8'h09, 4'd6}, // R6 status bit 4
    '{1'b1, 2'd2, 8'hD0, 8'h00, 1'b0, 8'hD0, 8'h09, 4'd4}, // R4 parity bit write ignored
    '{1'b1, 2'd2, 8'h20, 8'h01, 1'b0, 8'hE0, 8'h02, 4'd6}, // R6 unmapped bit
    '{1'b1, 2'd3, 8'h03, 8'h99, 1'b0, 8'h03, 8'h5A, 4'd5}, // R5 reserved kind
    '{1'b1, 2'd0, 8'h02, 8'h42, 1'b0, 8'h0A, 8'h42, 4'd2}, // R2 bank 1 R2
    '{1'b0, 2'd0, 8'h00, 8'h00, 1'b1, 8'h02, 8'h42, 4'd2}  // R2 Rn read in bank 1
  };

  task automatic check(input string what, input int req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] k, input logic [7:0] a, input logic [7:0] d,
                       input logic [2:0] fe, input logic [2:0] fv, input logic we);
    @(negedge clk);
    wr_en = we; wr_kind = k; wr_addr = a; wr_data = d;
    flag_en = fe; flag_val = fv;
    @(negedge clk);
    wr_en = 1'b0; flag_en = '0; flag_val = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state, R9 outputs
    check("acc in reset", 8, acc, 8'h00);
    check("b in reset", 8, b, 8'h00);
    check("psw in reset", 8, psw, 8'h00);
    check("bank in reset", 8, {6'b0, bank}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      write(VEC[i].kind, VEC[i].wa, VEC[i].wd, 3'b000, 3'b000, VEC[i].we);
      rd0_reg = VEC[i].rreg; rd0_addr = VEC[i].ra;
      #1;
      check($sformatf("vector %0d", i), int'(VEC[i].req), rd0_data, VEC[i].exp);
    end
    check("acc port", 9, acc, 8'h02);   // R9
    check("b port", 9, b, 8'hBC);       // R9
    check("bank port", 9, {6'b0, bank}, 8'h01);

    // R3 read during write returns old data
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'd1; wr_addr = 8'h0A; wr_data = 8'h99;
    rd0_reg = 1'b0; rd0_addr = 8'h0A; rd1_reg = 1'b1; rd1_addr = 8'h02;
    #1;
    check("old value port 0", 3, rd0_data, 8'h42);
    check("old value port 1", 3, rd1_data, 8'h42);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check("new value port 0", 3, rd0_data, 8'h99);
    check("new value port 1", 3, rd1_data, 8'h99);

    // R7 status write and flag load in one cycle
    write(2'd1, 8'hD0, 8'h00, 3'b101, 3'b101, 1'b1);
    check("write+flags", 7, psw, 8'h85);
    check("bank after write+flags", 7, {6'b0, bank}, 8'h00);
    write(2'd0, 8'h00, 8'h00, 3'b010, 3'b010, 1'b0);
    check("aux carry load", 7, psw, 8'hC5);
    write(2'd0, 8'h00, 8'h00, 3'b100, 3'b000, 1'b0);
    check("carry clear", 7, psw, 8'h45);
    write(2'd2, 8'hD7, 8'h01, 3'b100, 3'b000, 1'b1);
    check("bit write vs carry load", 7, psw, 8'h45);

    // R4 parity sweep
    for (int i = 0; i < 8; i++) begin
      write(2'd1, 8'hE0, 8'(1 << i), 3'b000, 3'b000, 1'b1);
      check($sformatf("parity one-hot %0d", i), 4, {7'b0, psw[0]}, 8'h01);
    end
    write(2'd1, 8'hE0, 8'hFF, 3'b000, 3'b000, 1'b1);
    check("parity all ones", 4, {7'b0, psw[0]}, 8'h00);

    // R8 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("acc after reset", 8, acc, 8'h00);
    check("psw after reset", 8, psw, 8'h00);
    check("b after reset", 8, b, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule